// File: doc/BRIEF.md
# Control-block flag priority dispatcher

This unit runs during vertical retrace. When a retrace-window pulse arrives, it reads a pointer to a monitor control block from a fixed memory address. It then checks the block's seal word and picks up the colour control block pointer. It reads the block's update-flag word, ORs those flags into a locally held pending set, and writes zero back to the flag word in memory.

In each retrace window it services at most one pending flag. Flags are scanned from the highest bit downward. Servicing a flag means raising a one-cycle request to the matching loader. The request carries the parameter address inside the colour control block and a transfer length in words. The dispatcher then waits for that loader's done signal before it accepts another retrace pulse.

If any timing flag (pixel clock, horizontal or vertical) is pending at dispatch, the unit also raises a restart-field request in the same cycle. A missing block (zero pointer) or a wrong seal disables processing and empties the pending set. The loaders themselves sit outside this block.

Top module: `ccb_flag_dispatch`

## Requirements
- R1: After reset, no service request, no restart request and no memory read or write is asserted.
- R2: If the pointer word at PTR_ADDR reads zero, the pending set is emptied, no request is raised, and the flag word is not written.
- R3: If the seal word at pointer+4 is not 16'o177456, the pending set is emptied, no request is raised, and the flag word at pointer+0 is left unchanged in memory.
- R4: On a valid block, the flag word at pointer+0 (bit 6 mixer, 5 pixel clock, 4 horizontal, 3 vertical, 2 table A, 1 table B, 0 table C) is ORed into the pending set. Zero is then written to the same address, so flags left over from earlier windows are kept.
- R5: Each retrace window services only the highest-numbered pending flag and removes it from the pending set. At most one svc_req bit is high, and it is high for one cycle.
- R6: A pending mixer flag (bit 6) is removed without raising any svc_req bit or waiting for done.
- R7: svc_addr equals the colour block pointer (read at pointer+3) plus the flag's offset: vertical 8, horizontal 11, pixel clock 14, table A 0, table B 2, table C 4.
- R8: svc_len is 2048 for table A, 256 for tables B and C, 3 for vertical and horizontal, and 1 for pixel clock.
- R9: restart is high in the dispatch cycle when any of bits 5, 4 or 3 is pending before removal. This includes a window in which only the mixer flag is serviced.
- R10: After raising a request, the unit ignores retrace pulses and makes no memory access until svc_done is seen.
- R11: Without a retrace pulse, the unit makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rtr_pulse | input | 1 | Retrace window start pulse |
| mem_rd | output | 1 | Memory read strobe, data returned one cycle later |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| svc_req | output | 7 | One-hot service request per flag, bit numbering as the flag word |
| svc_addr | output | DW | Parameter address in the colour control block |
| svc_len | output | LW | Transfer length in words |
| svc_done | input | 1 | Done from the loader last started |
| restart | output | 1 | Restart-field request |

## Verification
The assertions check four things on every cycle. At most one request is raised, and it never repeats on the next cycle. A table request never comes with a restart. The table A length is fixed. The single write always goes back to the address read two cycles before it. Priority order, merging of leftover flags, the effect of a missing pointer or a bad seal, mixer handling, offsets, and busy-time ignoring of pulses depend on memory contents across several retrace windows. Only the bench's directed scenarios can show those.

// File: rtl/ccb_flag_dispatch.sv
module ccb_flag_dispatch #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int LW = 12,
  parameter logic [AW-1:0] PTR_ADDR = 16'h000C,
  parameter logic [DW-1:0] SEAL = 16'o177456,
  parameter int SEAL_OFS = 4,
  parameter int CCB_OFS = 3,
  parameter int FLG_OFS = 0,
  parameter int LEN_TA = 2048,
  parameter int LEN_TBC = 256,
  parameter int LEN_VH = 3,
  parameter int LEN_PC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rtr_pulse,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [6:0]    svc_req,
  output logic [DW-1:0] svc_addr,
  output logic [LW-1:0] svc_len,
  input  logic          svc_done,
  output logic          restart
);
  localparam int NF = 7;
  localparam int MIX = 6;

  typedef enum logic [3:0] {
    S_IDLE, S_PTR, S_PTR_C, S_SEAL, S_SEAL_C, S_CCB, S_CCB_C,
    S_FLG, S_FLG_C, S_CLR, S_DISP, S_WAIT
  } st_t;

  st_t st;
  logic [DW-1:0] blk, ccb;
  logic [NF-1:0] pend;
  logic [2:0] top;
  logic any;

  always_comb begin
    top = '0;
    for (int i = 0; i < NF; i++)
      if (pend[i]) top = 3'(i);
  end
  assign any = |pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      blk <= '0;
      ccb <= '0;
      pend <= '0;
    end else begin
      case (st)
        S_IDLE:   if (rtr_pulse) st <= S_PTR;
        S_PTR:    st <= S_PTR_C;
        S_PTR_C: begin
          blk <= mem_rdata;
          if (mem_rdata == '0) begin
            pend <= '0;
            ccb <= '0;
            st <= S_IDLE;
          end else st <= S_SEAL;
        end
        S_SEAL:   st <= S_SEAL_C;
        S_SEAL_C: begin
          if (mem_rdata != SEAL) begin
            pend <= '0;
            ccb <= '0;
            st <= S_IDLE;
          end else st <= S_CCB;
        end
        S_CCB:    st <= S_CCB_C;
        S_CCB_C: begin
          ccb <= mem_rdata;
          st <= S_FLG;
        end
        S_FLG:    st <= S_FLG_C;
        S_FLG_C: begin
          pend <= pend | mem_rdata[NF-1:0];
          st <= S_CLR;
        end
        S_CLR:    st <= S_DISP;
        S_DISP: begin
          if (!any) st <= S_IDLE;
          else begin
            pend[top] <= 1'b0;
            st <= (top == 3'(MIX)) ? S_IDLE : S_WAIT;
          end
        end
        S_WAIT:   if (svc_done) st <= S_IDLE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  assign mem_rd = (st == S_PTR) || (st == S_SEAL) || (st == S_CCB) || (st == S_FLG);
  assign mem_wr = (st == S_CLR);
  assign mem_wdata = '0;

  always_comb begin
    case (st)
      S_PTR:   mem_addr = PTR_ADDR;
      S_SEAL:  mem_addr = AW'(blk + DW'(SEAL_OFS));
      S_CCB:   mem_addr = AW'(blk + DW'(CCB_OFS));
      default: mem_addr = AW'(blk + DW'(FLG_OFS));
    endcase
  end

  logic [DW-1:0] ofs;
  always_comb begin
    case (top)
      3'd5:    begin ofs = DW'(14); svc_len = LW'(LEN_PC);  end
      3'd4:    begin ofs = DW'(11); svc_len = LW'(LEN_VH);  end
      3'd3:    begin ofs = DW'(8);  svc_len = LW'(LEN_VH);  end
      3'd2:    begin ofs = DW'(0);  svc_len = LW'(LEN_TA);  end
      3'd1:    begin ofs = DW'(2);  svc_len = LW'(LEN_TBC); end
      3'd0:    begin ofs = DW'(4);  svc_len = LW'(LEN_TBC); end
      default: begin ofs = '0;      svc_len = '0;           end
    endcase
  end
  assign svc_addr = ccb + ofs;

  logic fire;
  assign fire = (st == S_DISP) && any && (top != 3'(MIX));
  assign svc_req = fire ? (7'b1 << top) : 7'b0;
  assign restart = (st == S_DISP) && (|pend[5:3]);
endmodule

module ccb_flag_dispatch_chk #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int LW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic [6:0]    svc_req,
  input logic [LW-1:0] svc_len,
  input logic          restart
);
  // R5
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(svc_req));
  // R5
  req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n) (|svc_req) |=> (svc_req == 7'b0));
  // R9
  table_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n) (|svc_req[2:0]) |-> !restart);
  // R8
  table_a_len_chk: assert property (@(posedge clk) disable iff (!rst_n) svc_req[2] |-> (svc_len == LW'(2048)));
  // R4
  wr_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($past(mem_rd, 2) && mem_addr == $past(mem_addr, 2)));
  // R1
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));
endmodule

bind ccb_flag_dispatch ccb_flag_dispatch_chk #(.AW(AW), .DW(DW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
  .svc_req(svc_req), .svc_len(svc_len), .restart(restart)
);

// File: tb/tb_ccb_flag_dispatch.sv
module tb_ccb_flag_dispatch;
  localparam int CLK_P = 10;
  logic clk = 0, rst_n = 0, rtr_pulse = 0, svc_done = 0;
  logic mem_rd, mem_wr, restart;
  logic [15:0] mem_addr, mem_wdata, svc_addr;
  logic [15:0] mem_rdata = '0;
  logic [6:0] svc_req;
  logic [11:0] svc_len;
  logic [15:0] mem [0:63];
  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  ccb_flag_dispatch dut (
    .clk(clk), .rst_n(rst_n), .rtr_pulse(rtr_pulse), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .svc_req(svc_req),
    .svc_addr(svc_addr), .svc_len(svc_len), .svc_done(svc_done), .restart(restart)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];
    if (mem_wr) mem[mem_addr[5:0]] <= mem_wdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setup(input logic [15:0] ptr, input logic [15:0] seal, input logic [15:0] ccb, input logic [15:0] flags);
    mem[12] = ptr;
    mem[16] = flags;
    mem[19] = ccb;
    mem[20] = seal;
  endtask

  logic [6:0] g_req;
  logic g_rs, g_rd;
  logic [15:0] g_addr;
  logic [11:0] g_len;

  task automatic retrace(input bit give_done);
    g_req = 0; g_rs = 0; g_rd = 0; g_addr = 0; g_len = 0;
    @(negedge clk) rtr_pulse = 1;
    @(negedge clk) rtr_pulse = 0;
    for (int i = 0; i < 20; i++) begin
      if (mem_rd || mem_wr) g_rd = 1;
      if (restart) g_rs = 1;
      if (svc_req != 0 && g_req == 0) begin
        g_req = svc_req; g_addr = svc_addr; g_len = svc_len;
      end
      @(negedge clk);
    end
    if (give_done && g_req != 0) begin
      svc_done = 1;
      @(negedge clk) svc_done = 0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 req", svc_req, 0);
    chk("R1 restart", restart, 0);
    chk("R1 rd", mem_rd, 0);
    chk("R1 wr", mem_wr, 0);
  endtask

  task automatic t_no_pulse;
    logic seen = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (mem_rd || mem_wr) seen = 1;
    end
    chk("R11 no access without pulse", seen, 0);
  endtask

  task automatic t_merge;
    setup(16, 16'o177456, 16'h1200, 16'h0003);
    retrace(1);
    chk("R5 B first", g_req, 7'h02);
    chk("R7 B addr", g_addr, 16'h1202);
    chk("R8 B len", g_len, 256);
    chk("R9 no restart", g_rs, 0);
    chk("R4 flag cleared", mem[16], 0);
    retrace(1);
    chk("R4 leftover C served", g_req, 7'h01);
    chk("R7 C addr", g_addr, 16'h1204);
  endtask

  task automatic t_prio_nullptr;
    setup(16, 16'o177456, 16'h0400, 16'h0007);
    retrace(1);
    chk("R5 A first", g_req, 7'h04);
    chk("R8 A len", g_len, 2048);
    chk("R7 A addr", g_addr, 16'h0400);
    mem[16] = 16'h0008;
    retrace(1);
    chk("R5 vertical over B", g_req, 7'h08);
    chk("R7 V addr", g_addr, 16'h0408);
    chk("R8 V len", g_len, 3);
    chk("R9 V restart", g_rs, 1);
    mem[12] = 0;
    retrace(1);
    chk("R2 zero ptr no req", g_req, 0);
    chk("R2 zero ptr flag untouched", mem[16], 0);
    mem[12] = 16;
    retrace(1);
    chk("R2 pending emptied", g_req, 0);
  endtask

  task automatic t_timing;
    setup(16, 16'o177456, 16'h2000, 16'h0030);
    retrace(1);
    chk("R7 PC addr", g_addr, 16'h200E);
    chk("R8 PC len", g_len, 1);
    chk("R9 PC restart", g_rs, 1);
    retrace(1);
    chk("R5 H next", g_req, 7'h10);
    chk("R7 H addr", g_addr, 16'h200B);
    chk("R8 H len", g_len, 3);
    chk("R9 H restart", g_rs, 1);
  endtask

  task automatic t_mixer;
    setup(16, 16'o177456, 16'h0100, 16'h0041);
    retrace(1);
    chk("R6 mixer no req", g_req, 0);
    chk("R9 mixer no restart", g_rs, 0);
    retrace(1);
    chk("R6 C after mixer", g_req, 7'h01);
    setup(16, 16'o177456, 16'h0100, 16'h0048);
    retrace(1);
    chk("R6 mixer no req 2", g_req, 0);
    chk("R9 mixer with V pending", g_rs, 1);
    retrace(1);
    chk("R5 V after mixer", g_req, 7'h08);
  endtask

  task automatic t_seal;
    setup(16, 16'o177456, 16'h0300, 16'h0006);
    retrace(1);
    chk("R5 A of A+B", g_req, 7'h04);
    setup(16, 16'o177457, 16'h0300, 16'h0000);
    retrace(1);
    chk("R3 bad seal no req", g_req, 0);
    mem[16] = 16'h0001;
    retrace(1);
    chk("R3 bad seal flag untouched", mem[16], 1);
    mem[16] = 0;
    mem[20] = 16'o177456;
    retrace(1);
    chk("R3 pending emptied", g_req, 0);
  endtask

  task automatic t_busy;
    setup(16, 16'o177456, 16'h0500, 16'h0003);
    retrace(0);
    chk("R10 B issued", g_req, 7'h02);
    retrace(0);
    chk("R10 ignored pulse no req", g_req, 0);
    chk("R10 ignored pulse no access", g_rd, 0);
    svc_done = 1;
    @(negedge clk) svc_done = 0;
    @(negedge clk);
    retrace(1);
    chk("R10 C after done", g_req, 7'h01);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_reset;
    t_no_pulse;
    t_merge;
    t_prio_nullptr;
    t_timing;
    t_mixer;
    t_seal;
    t_busy;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule